// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block sits in the fetch stage and guesses the next fetch address every cycle. It takes the current fetch address and a hint from predecode that says whether the fetched word holds no branch, a conditional branch or an unconditional branch. It then returns the address to fetch next, a taken flag and a flag that shows the target buffer held the branch. Branch targets live in a four-way set-associative target buffer. Conditional direction comes from a separate, larger table of two-bit saturating counters. That table is indexed only by address bits, so branches whose addresses share those bits also share a counter.

When a branch resolves further down the pipe, the update port reports its address, kind, outcome and target. If the branch is already held, the entry is trained. If it is not held and was taken (or is unconditional), a way is allocated for it. Return instructions, decode, cache access and flushing are handled elsewhere.

Top module: `branch_predictor`

## Requirements
- R1: With the hint at no-branch (00, or the unused code 11), predPc is fetchPc+4 and predTaken and predHit are 0, whatever the buffer holds.
- R2: With the hint at unconditional (10) and a matching valid entry, predHit and predTaken are 1 and predPc is the stored target.
- R3: With the hint at conditional (01) and a matching entry, predHit is 1. predTaken equals bit 1 of the direction counter selected by fetchPc[11:2], and predPc is the target when taken and fetchPc+4 when not.
- R4: A lookup with no matching valid entry in the set selected by fetchPc[8:2] gives predHit 0, predTaken 0 and predPc fetchPc+4.
- R5: A conditional update that hits moves the counter one step toward the outcome. The states are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken, and the counter saturates at 00 and at 11.
- R6: A taken conditional update that misses allocates an entry and sets its counter to 10. A not-taken conditional update that misses changes no state.
- R7: Allocation takes the lowest-numbered invalid way of the set. When all four ways are valid, it takes the way named by a 3-bit pseudo-LRU tree. Every update hit and every allocation marks its way most recent.
- R8: An active-high synchronous reset clears every valid bit and sets every direction counter to 01.
- R9: An update is visible to lookups from the next cycle on. A lookup in the same cycle as an update sees the old contents.
- R10: Addresses that differ only above bit 11 select the same direction counter, and each keeps its own buffer entry in the same set.
- R11: An update that hits rewrites the stored target when the branch is unconditional or was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | 32 | Current fetch address |
| fetchKind | input | 2 | Branch hint: 00 none, 01 conditional, 10 unconditional |
| predPc | output | 32 | Predicted next fetch address |
| predTaken | output | 1 | Prediction redirects fetch |
| predHit | output | 1 | Target buffer holds the branch |
| updEn | input | 1 | Resolved-branch update strobe |
| updPc | input | 32 | Address of the resolved branch |
| updKind | input | 2 | Kind of the resolved branch, same coding as fetchKind |
| updTaken | input | 1 | Resolved outcome |
| updTarget | input | 32 | Resolved target address |

## Verification
The hardest situation to reach from the ports is a pseudo-LRU victim choice in a full set. The tree bits cannot be seen, so they must be predicted from the whole history of hits and allocations in that set. The stimulus fills one set with branches whose addresses differ only in tag bits. Training hits on chosen ways steer the tree, and further allocations then show, through the lookup that now misses, which way was evicted. Because a 1024-entry history table is spread across 128 sets, the bench also builds a counter shared between two buffer entries and trains it through one entry while looking up the other.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int NUM_WAYS = 4;
  localparam int PLRU_W   = NUM_WAYS - 1;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_COND   = 2'b01,
    KIND_UNCOND = 2'b10,
    KIND_RSVD   = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                entryWe;
    logic [NUM_WAYS-1:0] wayOh;
    logic                ctrWe;
    ctr_e                ctrNext;
  } bp_strobe_t;

  function automatic ctr_e ctrTrain(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken && cur != CTR_ST)       nxt = ctr_e'(cur + 2'd1);
    else if (!taken && cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SET_BITS   = 7,
  parameter int HIST_BITS  = 10,
  parameter int ALIGN_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   fetchPc,
  input  logic [1:0]          fetchKind,
  input  logic [ADDR_W-1:0]   updPc,
  input  logic [ADDR_W-1:0]   updTarget,
  input  bp_strobe_t          strb,
  output logic [ADDR_W-1:0]   predPc,
  output logic                predTaken,
  output logic                predHit,
  output logic [NUM_WAYS-1:0] updMatch,
  output logic [NUM_WAYS-1:0] updValidVec,
  output ctr_e                updCtr
);

  localparam int SETS   = 1 << SET_BITS;
  localparam int HIST   = 1 << HIST_BITS;
  localparam int TAG_W  = ADDR_W - SET_BITS;
  localparam int HI_LSB = ALIGN_BITS + SET_BITS;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

  logic [SET_BITS-1:0]  fetchSet, updSet;
  logic [TAG_W-1:0]     fetchTag, updTag;
  logic [HIST_BITS-1:0] fetchHist, updHist;

  // Tag keeps the alignment bits too, so the match is on the exact address
  assign fetchSet  = fetchPc[ALIGN_BITS +: SET_BITS];
  assign updSet    = updPc[ALIGN_BITS +: SET_BITS];
  assign fetchTag  = {fetchPc[ADDR_W-1:HI_LSB], fetchPc[ALIGN_BITS-1:0]};
  assign updTag    = {updPc[ADDR_W-1:HI_LSB], updPc[ALIGN_BITS-1:0]};
  assign fetchHist = fetchPc[ALIGN_BITS +: HIST_BITS];
  assign updHist   = updPc[ALIGN_BITS +: HIST_BITS];

  logic [NUM_WAYS-1:0] wayHit;
  logic [ADDR_W-1:0]   wayTgt [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagMem [SETS];
    logic [ADDR_W-1:0] tgtMem [SETS];
    logic [SETS-1:0]   validMem;

    always_ff @(posedge clk) begin
      if (rst) begin
        validMem <= '0;
      end else if (strb.entryWe && strb.wayOh[w]) begin
        validMem[updSet] <= 1'b1;
        tagMem[updSet]   <= updTag;
        tgtMem[updSet]   <= updTarget;
      end
    end

    assign wayHit[w]      = validMem[fetchSet] && (tagMem[fetchSet] == fetchTag);
    assign wayTgt[w]      = tgtMem[fetchSet];
    assign updValidVec[w] = validMem[updSet];
    assign updMatch[w]    = validMem[updSet] && (tagMem[updSet] == updTag);
  end

  // Direction counters
  ctr_e ctrMem [HIST];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) ctrMem[i] <= CTR_WNT;
    end else if (strb.ctrWe) begin
      ctrMem[updHist] <= strb.ctrNext;
    end
  end

  assign updCtr = ctrMem[updHist];

  logic [ADDR_W-1:0] hitTgt;
  logic              anyHit;
  ctr_e              fetchCtr;
  br_kind_e          kind;

  always_comb begin
    hitTgt = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wayHit[w]) hitTgt = hitTgt | wayTgt[w];
    end
  end

  assign anyHit   = |wayHit;
  assign fetchCtr = ctrMem[fetchHist];
  assign kind     = br_kind_e'(fetchKind);

  always_comb begin
    predHit   = 1'b0;
    predTaken = 1'b0;
    unique case (kind)
      KIND_UNCOND: begin
        predHit   = anyHit;
        predTaken = anyHit;
      end
      KIND_COND: begin
        predHit   = anyHit;
        predTaken = anyHit && fetchCtr[1];
      end
      default: begin
        predHit   = 1'b0;
        predTaken = 1'b0;
      end
    endcase
    predPc = predTaken ? hitTgt : fetchPc + STEP;
  end

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int SET_BITS = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                updEn,
  input  logic [1:0]          updKind,
  input  logic                updTaken,
  input  logic [SET_BITS-1:0] updSet,
  input  logic [NUM_WAYS-1:0] updMatch,
  input  logic [NUM_WAYS-1:0] updValidVec,
  input  ctr_e                updCtr,
  output bp_strobe_t          strb
);

  localparam int SETS = 1 << SET_BITS;

  // Tree bits: [0] root (0 -> victim in ways 0/1), [1] picks within 0/1, [2] within 2/3
  logic [PLRU_W-1:0] plruMem [SETS];
  logic [PLRU_W-1:0] plruCur, plruNext;

  br_kind_e            kind;
  logic                isBranch, anyHit, doHit, doAlloc, touch;
  logic [NUM_WAYS-1:0] freeOh, victimOh, allocOh, touchOh;

  assign kind     = br_kind_e'(updKind);
  assign isBranch = (kind == KIND_COND) || (kind == KIND_UNCOND);
  assign anyHit   = |updMatch;
  assign plruCur  = plruMem[updSet];

  // Lowest-numbered invalid way
  assign freeOh = ~updValidVec & (updValidVec + NUM_WAYS'(1));

  always_comb begin
    if (!plruCur[0]) victimOh = plruCur[1] ? 4'b0010 : 4'b0001;
    else             victimOh = plruCur[2] ? 4'b1000 : 4'b0100;
  end

  assign allocOh = (|freeOh) ? freeOh : victimOh;

  assign doHit   = updEn && isBranch && anyHit;
  assign doAlloc = updEn && isBranch && !anyHit && ((kind == KIND_UNCOND) || updTaken);
  assign touch   = doHit || doAlloc;
  assign touchOh = doHit ? updMatch : (doAlloc ? allocOh : '0);

  // Point the tree away from the way just used
  always_comb begin
    plruNext = plruCur;
    unique case (1'b1)
      touchOh[0]: begin plruNext[0] = 1'b1; plruNext[1] = 1'b1; end
      touchOh[1]: begin plruNext[0] = 1'b1; plruNext[1] = 1'b0; end
      touchOh[2]: begin plruNext[0] = 1'b0; plruNext[2] = 1'b1; end
      touchOh[3]: begin plruNext[0] = 1'b0; plruNext[2] = 1'b0; end
      default:    plruNext = plruCur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) plruMem[s] <= '0;
    end else if (touch) begin
      plruMem[updSet] <= plruNext;
    end
  end

  always_comb begin
    strb.entryWe = doAlloc || (doHit && ((kind == KIND_UNCOND) || updTaken));
    strb.wayOh   = touchOh;
    strb.ctrWe   = (kind == KIND_COND) && touch;
    strb.ctrNext = doAlloc ? CTR_WT : ctrTrain(updCtr, updTaken);
  end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SET_BITS   = 7,
  parameter int HIST_BITS  = 10,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [1:0]        fetchKind,
  output logic [ADDR_W-1:0] predPc,
  output logic              predTaken,
  output logic              predHit,
  input  logic              updEn,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [1:0]        updKind,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);

  bp_strobe_t          strb;
  logic [NUM_WAYS-1:0] updMatch, updValidVec;
  ctr_e                updCtr;

  bp_datapath #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS),
    .HIST_BITS(HIST_BITS), .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk(clk), .rst(rst),
    .fetchPc(fetchPc), .fetchKind(fetchKind),
    .updPc(updPc), .updTarget(updTarget),
    .strb(strb),
    .predPc(predPc), .predTaken(predTaken), .predHit(predHit),
    .updMatch(updMatch), .updValidVec(updValidVec), .updCtr(updCtr)
  );

  bp_ctrl #(.SET_BITS(SET_BITS)) u_ctrl (
    .clk(clk), .rst(rst),
    .updEn(updEn), .updKind(updKind), .updTaken(updTaken),
    .updSet(updPc[ALIGN_BITS +: SET_BITS]),
    .updMatch(updMatch), .updValidVec(updValidVec), .updCtr(updCtr),
    .strb(strb)
  );

endmodule

// File: rtl/bp_checker.sv
module bp_checker
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetchPc,
  input logic [1:0]        fetchKind,
  input logic [ADDR_W-1:0] predPc,
  input logic              predTaken,
  input logic              predHit,
  input logic              updEn,
  input logic [ADDR_W-1:0] updPc,
  input logic [1:0]        updKind,
  input logic [ADDR_W-1:0] updTarget,
  input bp_strobe_t        strb
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

  logic afterRst = 1'b0;
  always_ff @(posedge clk) afterRst <= rst;

  // R1
  nobranch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fetchKind == 2'b00 || fetchKind == 2'b11) |-> (!predTaken && !predHit));

  // R4
  miss_sequential_chk: assert property (@(posedge clk) disable iff (rst)
    !predHit |-> (!predTaken && predPc == fetchPc + STEP));

  // R2
  uncond_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (predHit && fetchKind == 2'b10) |-> predTaken);

  // R7
  single_way_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.wayOh));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    (afterRst && !rst) |-> !predHit);

  // R9
  update_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (updEn && updKind == 2'b10) |=>
      (!(fetchPc == $past(updPc) && fetchKind == 2'b10) ||
       (predHit && predPc == $past(updTarget))));

endmodule

bind branch_predictor bp_checker #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchKind(fetchKind),
  .predPc(predPc), .predTaken(predTaken), .predHit(predHit),
  .updEn(updEn), .updPc(updPc), .updKind(updKind), .updTarget(updTarget),
  .strb(strb)
);

// File: tb/branch_predictor_bench.sv
`timescale 1ns/1ps
module branch_predictor_bench;

  localparam logic [1:0] NB = 2'b00, CD = 2'b01, UC = 2'b10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchPc = '0;
  logic [1:0]  fetchKind = NB;
  logic [31:0] predPc;
  logic        predTaken, predHit;
  logic        updEn = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updKind = NB;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;

  always #2.5 clk = ~clk;

  branch_predictor u_branch_predictor (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchKind(fetchKind),
    .predPc(predPc), .predTaken(predTaken), .predHit(predHit),
    .updEn(updEn), .updPc(updPc), .updKind(updKind),
    .updTaken(updTaken), .updTarget(updTarget)
  );

  typedef struct {
    logic [31:0] ePc;
    logic        eTaken;
    logic        eHit;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  logic        pendEn = 1'b0;
  logic [31:0] pendPc, pendTgt;
  logic [1:0]  pendKind;
  logic        pendTaken;

  // Monitor: compares mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t it;
      it = expQ.pop_front();
      tests++;
      if (predPc !== it.ePc || predTaken !== it.eTaken || predHit !== it.eHit) begin
        fails++;
        $display("FAIL %s: got pc=%h taken=%b hit=%b, expected pc=%h taken=%b hit=%b",
                 it.tag, predPc, predTaken, predHit, it.ePc, it.eTaken, it.eHit);
      end
    end
  end

  task automatic upd(input logic [31:0] pc, input logic [1:0] kind,
                     input logic taken, input logic [31:0] tgt);
    pendEn = 1'b1; pendPc = pc; pendKind = kind; pendTaken = taken; pendTgt = tgt;
  endtask

  // Driver: one cycle, lookup plus any pending update, expectation queued
  task automatic cyc(input logic [31:0] pc, input logic [1:0] kind,
                     input logic [31:0] ePc, input logic eTaken, input logic eHit,
                     input string tag);
    @(posedge clk); #1;
    fetchPc = pc; fetchKind = kind;
    updEn = pendEn; updPc = pendPc; updKind = pendKind;
    updTaken = pendTaken; updTarget = pendTgt;
    pendEn = 1'b0;
    expQ.push_back('{ePc, eTaken, eHit, tag});
  endtask

  task automatic train(input logic [31:0] pc, input logic [1:0] kind,
                       input logic taken, input logic [31:0] tgt);
    upd(pc, kind, taken, tgt);
    cyc(pc, NB, pc + 4, 1'b0, 1'b0, "R1 during update");
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rst = 1'b1; updEn = 1'b0; fetchKind = NB;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h1000, B = 32'h1200, C = 32'h1400, D = 32'h1600;
  localparam logic [31:0] E = 32'h1800, F = 32'h1A00, G = 32'h2000;
  localparam logic [31:0] T1 = 32'h9000, T2 = 32'h9100;

  initial begin
    doReset();
    // reset state and basic misses
    cyc(A, CD, A + 4, 0, 0, "R8 empty after reset");
    cyc(A, NB, A + 4, 0, 0, "R1 no branch");
    cyc(A, UC, A + 4, 0, 0, "R4 uncond miss");
    // not-taken miss allocates nothing
    upd(A, CD, 0, T1); cyc(A, CD, A + 4, 0, 0, "R6 miss");
    cyc(A, CD, A + 4, 0, 0, "R6 not-taken miss no alloc");
    // taken miss allocates; same-cycle lookup sees old contents
    upd(A, CD, 1, T1); cyc(A, CD, A + 4, 0, 0, "R9 old contents");
    cyc(A, CD, T1, 1, 1, "R6 alloc weakly taken");
    cyc(A, NB, A + 4, 0, 0, "R1 hint none ignores hit");
    cyc(A, 2'b11, A + 4, 0, 0, "R1 reserved hint");
    // counter walk
    train(A, CD, 0, T1); cyc(A, CD, A + 4, 0, 1, "R3 weak not-taken");
    train(A, CD, 0, T1); cyc(A, CD, A + 4, 0, 1, "R5 strong not-taken");
    train(A, CD, 0, T1); cyc(A, CD, A + 4, 0, 1, "R5 floor");
    train(A, CD, 1, T1); cyc(A, CD, A + 4, 0, 1, "R5 floor held one step");
    train(A, CD, 1, T1); cyc(A, CD, T1, 1, 1, "R3 weak taken");
    train(A, CD, 1, T1); cyc(A, CD, T1, 1, 1, "R5 strong taken");
    train(A, CD, 1, T1); cyc(A, CD, T1, 1, 1, "R5 ceiling");
    train(A, CD, 0, T1); cyc(A, CD, T1, 1, 1, "R5 ceiling held one step");
    train(A, CD, 0, T1); cyc(A, CD, A + 4, 0, 1, "R5 back to weak not-taken");
    // shared counter across tags
    train(G, UC, 1, 32'hA000); cyc(G, UC, 32'hA000, 1, 1, "R2 uncond hit");
    cyc(G, CD, G + 4, 0, 1, "R10 shared counter not-taken");
    cyc(A, CD, A + 4, 0, 1, "R10 own entry kept");
    train(A, CD, 1, T1); cyc(G, CD, 32'hA000, 1, 1, "R10 trained via other entry");
    // target rewrite
    train(G, UC, 1, 32'hB000); cyc(G, UC, 32'hB000, 1, 1, "R11 uncond rewrite");
    train(A, CD, 1, T2); cyc(A, CD, T2, 1, 1, "R11 taken cond rewrite");
    // fill the set: invalid ways first
    train(B, UC, 1, 32'hC000); cyc(B, UC, 32'hC000, 1, 1, "R7 fill way2");
    train(C, UC, 1, 32'hC100); cyc(G, UC, 32'hB000, 1, 1, "R7 invalid way before LRU");
    cyc(C, UC, 32'hC100, 1, 1, "R7 fill way3");
    // full set: tree victims
    train(D, UC, 1, 32'hC200); cyc(G, UC, G + 4, 0, 0, "R7 evict way1");
    cyc(D, UC, 32'hC200, 1, 1, "R7 new entry");
    cyc(A, CD, T2, 1, 1, "R7 way0 survives");
    train(E, UC, 1, 32'hC300); cyc(B, UC, B + 4, 0, 0, "R7 evict way2");
    cyc(E, UC, 32'hC300, 1, 1, "R7 new entry");
    train(A, CD, 1, T2); train(F, UC, 1, 32'hC400);
    cyc(C, UC, C + 4, 0, 0, "R7 hit steers eviction to way3");
    cyc(F, UC, 32'hC400, 1, 1, "R7 new entry");
    cyc(D, UC, 32'hC200, 1, 1, "R7 way1 survives");
    cyc(A, CD, T2, 1, 1, "R7 touched way survives");
    cyc(A + 4, UC, A + 8, 0, 0, "R4 other set miss");
    // reset clears everything
    doReset();
    cyc(D, UC, D + 4, 0, 0, "R8 valid cleared");
    train(G, UC, 1, 32'hA000); cyc(G, CD, G + 4, 0, 1, "R8 counter weak not-taken");
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule